// File: doc/BRIEF.md
# Issue queue with selectable ordering

This block is an instruction issue queue for an out-of-order core model. The dispatch stage sends it entries. Each entry carries a sequence tag, a one-hot pipe-target class, and two source operands, each with a physical tag and a ready flag. An entry waits in a holding buffer until both of its sources are ready. Two wakeup ports broadcast destination tags, and any matching source flag is set. Ready entries then move, one per cycle, into a separate ready list. The head of that list is steered to one execution unit out of a contiguous, inclusive range of unit indices.

A run-time input sets how the ready list is ordered. With the input high, the list keeps the order in which entries became ready. With the input low, the entry with the oldest sequence tag is issued first, and the age compare handles tag wrap. Each served unit has a parameterised capability mask over the class bits. The head entry goes to the lowest-indexed free unit whose mask covers its class. If no such unit is free, the head waits and nothing behind it is issued.

Top module: `iq_ordered_issue`

## Requirements
- R1: After reset, `disp_ready_o` is 1 and `iss_valid_o` is all zeros.
- R2: A source flag is set when a valid wakeup on either port carries the same tag. This includes a wakeup in the same cycle that the entry is dispatched. A wakeup whose tag matches no waiting source has no effect, and an entry with an unready source is never issued.
- R3: An entry whose last source becomes ready at clock edge k enters the ready list at edge k+1. If a capable unit is free, the entry is presented on the issue outputs during the cycle that follows edge k+1.
- R4: With `in_order_i` = 1 (the default setting), a newly ready entry is placed behind every entry already in the ready list.
- R5: With `in_order_i` = 0, a newly ready entry is placed ahead of every listed entry that is younger than itself. Tag a is older than tag b when (a − b) modulo 2^SEQ_W has its top bit set. For example, with 6-bit tags the order is 62, 63, 0, 1.
- R6: The class encoding is bit 0 integer, bit 1 multiply, bit 2 divide, bit 3 branch. The default units 2, 3 and 4 accept {integer}, {integer, divide} and {integer, multiply}. The head is sent to the lowest-indexed free unit whose mask shares a bit with its class. `iss_valid_o[i]` stands for unit FIRST_UNIT+i. `iss_valid_o` has at most one bit set, and `iss_unit_o` gives the absolute unit index.
- R7: If no capable unit is free, the head stays at the front of the list, nothing is issued, and it issues once a capable unit frees.
- R8: When every holding slot is occupied, `disp_ready_o` is 0, a presented dispatch is dropped, and entries already held are kept unchanged. `disp_ready_o` returns to 1 after the first transfer out of the buffer.
- R9: At most one entry moves from the holding buffer to the ready list per cycle. Among several ready entries, the one with the oldest sequence tag moves first.
- R10: At most one entry issues per cycle. An issued entry leaves the list at that clock edge and is never issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_order_i | input | 1 | 1: arrival order; 0: oldest tag first |
| disp_valid_i | input | 1 | Dispatch entry presented |
| disp_ready_o | output | 1 | A holding slot is free |
| disp_seq_i | input | SEQ_W (6) | Sequence tag of the entry |
| disp_cls_i | input | NCLS (4) | One-hot pipe-target class |
| disp_src0_tag_i | input | PTAG_W (5) | First source tag |
| disp_src0_rdy_i | input | 1 | First source already ready |
| disp_src1_tag_i | input | PTAG_W (5) | Second source tag |
| disp_src1_rdy_i | input | 1 | Second source already ready |
| wk0_valid_i | input | 1 | Wakeup port 0 valid |
| wk0_tag_i | input | PTAG_W (5) | Wakeup port 0 destination tag |
| wk1_valid_i | input | 1 | Wakeup port 1 valid |
| wk1_tag_i | input | PTAG_W (5) | Wakeup port 1 destination tag |
| unit_free_i | input | LAST_UNIT−FIRST_UNIT+1 | Bit i: unit FIRST_UNIT+i can accept |
| iss_valid_o | output | LAST_UNIT−FIRST_UNIT+1 | One-hot issue strobe per served unit |
| iss_unit_o | output | clog2(LAST_UNIT+1) | Absolute index of the target unit |
| iss_seq_o | output | SEQ_W (6) | Sequence tag of the issued entry |
| iss_cls_o | output | NCLS (4) | Class of the issued entry |

## Verification
An entry that is ready when it is dispatched, or whose flag a wakeup sets at edge k, is absent from the issue outputs in the cycle after edge k. It appears in the cycle after edge k+1, and the bench samples exactly those two mid-cycle points. Issue outputs depend combinationally on `unit_free_i` and on the head of the list. The bench changes inputs just after a rising edge and reads results at the falling edge, so every issue it expects is due in the same cycle that the unit mask allows it. The ordering tests hold all units busy until the ready list has been filled, then release them. Each following cycle must issue the next queued tag in the required order.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned SEQ_W  = 6;
  localparam int unsigned PTAG_W = 5;
  localparam int unsigned NCLS   = 4;

  typedef logic [SEQ_W-1:0]  seq_t;
  typedef logic [PTAG_W-1:0] ptag_t;
  typedef logic [NCLS-1:0]   cls_t;

  typedef struct packed {
    seq_t seq;
    cls_t cls;
  } rdy_ent_t;

  typedef struct packed {
    logic  vld;
    seq_t  seq;
    cls_t  cls;
    ptag_t tag0;
    logic  rdy0;
    ptag_t tag1;
    logic  rdy1;
  } hold_ent_t;

  // wrap-aware age compare: a is older than b
  function automatic logic seq_older(input seq_t a, input seq_t b);
    seq_t diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction
endpackage

// File: rtl/iq_hold_buf.sv
module iq_hold_buf
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     disp_valid_i,
  output logic     disp_ready_o,
  input  seq_t     disp_seq_i,
  input  cls_t     disp_cls_i,
  input  ptag_t    disp_tag0_i,
  input  logic     disp_rdy0_i,
  input  ptag_t    disp_tag1_i,
  input  logic     disp_rdy1_i,
  input  logic     wk0_valid_i,
  input  ptag_t    wk0_tag_i,
  input  logic     wk1_valid_i,
  input  ptag_t    wk1_tag_i,
  input  logic     xfer_ok_i,
  output logic     xfer_valid_o,
  output rdy_ent_t xfer_ent_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  hold_ent_t        ent_q [DEPTH];
  hold_ent_t        ent_d [DEPTH];
  logic [DEPTH-1:0] alloc_oh;
  logic [DEPTH-1:0] xfer_oh;
  logic [IDX_W-1:0] best_idx;
  logic             disp_fire;
  logic             xfer_fire;
  logic             upd_en;

  function automatic logic tag_woken(input ptag_t t, input logic v0, input ptag_t t0,
                                     input logic v1, input ptag_t t1);
    return (v0 && (t0 == t)) || (v1 && (t1 == t));
  endfunction

  // free-slot allocation and oldest-ready selection
  always_comb begin : pick_c
    logic got_free;
    logic got_rdy;
    alloc_oh = '0;
    xfer_oh  = '0;
    best_idx = '0;
    got_free = 1'b0;
    got_rdy  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!ent_q[i].vld && !got_free) begin
        alloc_oh[i] = 1'b1;
        got_free    = 1'b1;
      end
      if (ent_q[i].vld && ent_q[i].rdy0 && ent_q[i].rdy1) begin
        if (!got_rdy || seq_older(ent_q[i].seq, ent_q[best_idx].seq)) begin
          best_idx = IDX_W'(i);
          got_rdy  = 1'b1;
        end
      end
    end
    if (got_rdy) xfer_oh[best_idx] = 1'b1;
    disp_ready_o = got_free;
    xfer_valid_o = got_rdy;
  end

  assign xfer_ent_o = '{seq: ent_q[best_idx].seq, cls: ent_q[best_idx].cls};
  assign disp_fire  = disp_valid_i & disp_ready_o;
  assign xfer_fire  = xfer_valid_o & xfer_ok_i;
  assign upd_en     = disp_fire | xfer_fire | wk0_valid_i | wk1_valid_i;

  always_comb begin : next_c
    for (int i = 0; i < DEPTH; i++) begin
      ent_d[i] = ent_q[i];
      if (xfer_fire && xfer_oh[i]) begin
        ent_d[i].vld = 1'b0;
      end else if (ent_q[i].vld) begin
        if (tag_woken(ent_q[i].tag0, wk0_valid_i, wk0_tag_i, wk1_valid_i, wk1_tag_i))
          ent_d[i].rdy0 = 1'b1;
        if (tag_woken(ent_q[i].tag1, wk0_valid_i, wk0_tag_i, wk1_valid_i, wk1_tag_i))
          ent_d[i].rdy1 = 1'b1;
      end
      if (disp_fire && alloc_oh[i]) begin
        ent_d[i].vld  = 1'b1;
        ent_d[i].seq  = disp_seq_i;
        ent_d[i].cls  = disp_cls_i;
        ent_d[i].tag0 = disp_tag0_i;
        ent_d[i].tag1 = disp_tag1_i;
        ent_d[i].rdy0 = disp_rdy0_i |
                        tag_woken(disp_tag0_i, wk0_valid_i, wk0_tag_i, wk1_valid_i, wk1_tag_i);
        ent_d[i].rdy1 = disp_rdy1_i |
                        tag_woken(disp_tag1_i, wk0_valid_i, wk0_tag_i, wk1_valid_i, wk1_tag_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (upd_en) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot_chk
      // R8
      held_slot_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_q[g].vld && !(xfer_fire && xfer_oh[g]))
          |=> (ent_q[g].vld && (ent_q[g].seq == $past(ent_q[g].seq))));
    end
  endgenerate
endmodule

// File: rtl/iq_ready_list.sv
module iq_ready_list
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_order_i,
  input  logic     push_i,
  input  rdy_ent_t push_ent_i,
  input  logic     pop_i,
  output logic     room_o,
  output logic     head_valid_o,
  output rdy_ent_t head_ent_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rdy_ent_t         slot_q [DEPTH];
  rdy_ent_t         slot_d [DEPTH];
  rdy_ent_t         rem    [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] rem_cnt;
  logic [CNT_W-1:0] ins_pos;
  logic             upd_en;

  always_comb begin : next_c
    for (int i = 0; i < DEPTH; i++) begin
      if (!pop_i)             rem[i] = slot_q[i];
      else if (i + 1 < DEPTH) rem[i] = slot_q[(i + 1) % DEPTH];
      else                    rem[i] = '0;
    end
    rem_cnt = cnt_q - CNT_W'(pop_i);
    ins_pos = rem_cnt;
    if (!in_order_i) begin
      ins_pos = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if ((CNT_W'(i) < rem_cnt) && seq_older(rem[i].seq, push_ent_i.seq))
          ins_pos = ins_pos + 1'b1;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (!push_i || (CNT_W'(i) < ins_pos)) slot_d[i] = rem[i];
      else if (CNT_W'(i) == ins_pos)        slot_d[i] = push_ent_i;
      else                                   slot_d[i] = rem[(i + DEPTH - 1) % DEPTH];
    end
    cnt_d = rem_cnt + CNT_W'(push_i);
  end

  assign upd_en       = push_i | pop_i;
  assign room_o       = (cnt_q != CNT_W'(DEPTH));
  assign head_valid_o = (cnt_q != '0);
  assign head_ent_o   = slot_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  // R10
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4
  arrival_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && in_order_i) |=> (slot_q[$past(cnt_q)] == $past(push_ent_i)));
endmodule

// File: rtl/iq_steer.sv
module iq_steer
  import iq_pkg::*;
#(
  parameter int unsigned NUNITS = 3,
  parameter logic [NUNITS*NCLS-1:0] CAPS = '1,
  localparam int unsigned OFF_W = (NUNITS > 1) ? $clog2(NUNITS) : 1
) (
  input  logic              head_valid_i,
  input  cls_t              head_cls_i,
  input  logic [NUNITS-1:0] unit_free_i,
  output logic [NUNITS-1:0] grant_o,
  output logic [OFF_W-1:0]  grant_idx_o
);
  logic [NUNITS-1:0] cap_ok;
  logic [NUNITS-1:0] cand;

  generate
    for (genvar u = 0; u < NUNITS; u++) begin : g_cap
      assign cap_ok[u] = |(CAPS[u*NCLS +: NCLS] & head_cls_i);
    end
  endgenerate

  assign cand = cap_ok & unit_free_i & {NUNITS{head_valid_i}};

  always_comb begin : pick_c
    logic got;
    grant_o     = '0;
    grant_idx_o = '0;
    got         = 1'b0;
    for (int u = 0; u < NUNITS; u++) begin
      if (cand[u] && !got) begin
        grant_o[u]  = 1'b1;
        grant_idx_o = OFF_W'(u);
        got         = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iq_ordered_issue.sv
module iq_ordered_issue
  import iq_pkg::*;
#(
  parameter int unsigned HOLD_DEPTH = 4,
  parameter int unsigned RDY_DEPTH  = 4,
  parameter int unsigned FIRST_UNIT = 2,
  parameter int unsigned LAST_UNIT  = 4,
  parameter logic [(LAST_UNIT-FIRST_UNIT+1)*iq_pkg::NCLS-1:0] UNIT_CAPS = 12'h351
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_order_i,
  input  logic                              disp_valid_i,
  output logic                              disp_ready_o,
  input  logic [iq_pkg::SEQ_W-1:0]          disp_seq_i,
  input  logic [iq_pkg::NCLS-1:0]           disp_cls_i,
  input  logic [iq_pkg::PTAG_W-1:0]         disp_src0_tag_i,
  input  logic                              disp_src0_rdy_i,
  input  logic [iq_pkg::PTAG_W-1:0]         disp_src1_tag_i,
  input  logic                              disp_src1_rdy_i,
  input  logic                              wk0_valid_i,
  input  logic [iq_pkg::PTAG_W-1:0]         wk0_tag_i,
  input  logic                              wk1_valid_i,
  input  logic [iq_pkg::PTAG_W-1:0]         wk1_tag_i,
  input  logic [LAST_UNIT-FIRST_UNIT:0]     unit_free_i,
  output logic [LAST_UNIT-FIRST_UNIT:0]     iss_valid_o,
  output logic [$clog2(LAST_UNIT+1)-1:0]    iss_unit_o,
  output logic [iq_pkg::SEQ_W-1:0]          iss_seq_o,
  output logic [iq_pkg::NCLS-1:0]           iss_cls_o
);
  localparam int unsigned NUNITS = LAST_UNIT - FIRST_UNIT + 1;
  localparam int unsigned UNIT_W = $clog2(LAST_UNIT + 1);
  localparam int unsigned OFF_W  = (NUNITS > 1) ? $clog2(NUNITS) : 1;

  logic       xfer_valid;
  logic       rl_room;
  logic       rl_head_valid;
  logic       rl_pop;
  rdy_ent_t   xfer_ent;
  rdy_ent_t   rl_head;
  logic [OFF_W-1:0] grant_idx;

  iq_hold_buf #(.DEPTH(HOLD_DEPTH)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .disp_valid_i (disp_valid_i),
    .disp_ready_o (disp_ready_o),
    .disp_seq_i   (disp_seq_i),
    .disp_cls_i   (disp_cls_i),
    .disp_tag0_i  (disp_src0_tag_i),
    .disp_rdy0_i  (disp_src0_rdy_i),
    .disp_tag1_i  (disp_src1_tag_i),
    .disp_rdy1_i  (disp_src1_rdy_i),
    .wk0_valid_i  (wk0_valid_i),
    .wk0_tag_i    (wk0_tag_i),
    .wk1_valid_i  (wk1_valid_i),
    .wk1_tag_i    (wk1_tag_i),
    .xfer_ok_i    (rl_room),
    .xfer_valid_o (xfer_valid),
    .xfer_ent_o   (xfer_ent)
  );

  iq_ready_list #(.DEPTH(RDY_DEPTH)) u_rlist (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_order_i   (in_order_i),
    .push_i       (xfer_valid & rl_room),
    .push_ent_i   (xfer_ent),
    .pop_i        (rl_pop),
    .room_o       (rl_room),
    .head_valid_o (rl_head_valid),
    .head_ent_o   (rl_head)
  );

  iq_steer #(.NUNITS(NUNITS), .CAPS(UNIT_CAPS)) u_steer (
    .head_valid_i (rl_head_valid),
    .head_cls_i   (rl_head.cls),
    .unit_free_i  (unit_free_i),
    .grant_o      (iss_valid_o),
    .grant_idx_o  (grant_idx)
  );

  assign rl_pop     = |iss_valid_o;
  assign iss_unit_o = UNIT_W'(FIRST_UNIT) + UNIT_W'(grant_idx);
  assign iss_seq_o  = rl_head.seq;
  assign iss_cls_o  = rl_head.cls;

  // R6
  iss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iss_valid_o));

  // R6
  iss_to_free_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_valid_o & ~unit_free_i) == '0));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_i && !disp_ready_o && !xfer_valid) |=> !disp_ready_o);
endmodule

// File: tb/sim_iq_ordered_issue.sv
module sim_iq_ordered_issue;
  localparam int CLK_P = 10;
  localparam int C_INT = 1, C_MUL = 2, C_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_order;
  logic       disp_valid, disp_ready;
  logic [5:0] disp_seq;
  logic [3:0] disp_cls;
  logic [4:0] t0, t1;
  logic       r0, r1;
  logic       wk0_v, wk1_v;
  logic [4:0] wk0_tag, wk1_tag;
  logic [2:0] unit_free;
  logic [2:0] iss_valid;
  logic [2:0] iss_unit;
  logic [5:0] iss_seq;
  logic [3:0] iss_cls;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  logic [8:0] exp_q[$];
  string      exp_r[$];
  logic [8:0] mon_e;
  string      mon_r;

  always #(CLK_P/2) clk = ~clk;

  iq_ordered_issue u0 (
    .clk(clk), .rst_n(rst_n), .in_order_i(in_order),
    .disp_valid_i(disp_valid), .disp_ready_o(disp_ready),
    .disp_seq_i(disp_seq), .disp_cls_i(disp_cls),
    .disp_src0_tag_i(t0), .disp_src0_rdy_i(r0),
    .disp_src1_tag_i(t1), .disp_src1_rdy_i(r1),
    .wk0_valid_i(wk0_v), .wk0_tag_i(wk0_tag),
    .wk1_valid_i(wk1_v), .wk1_tag_i(wk1_tag),
    .unit_free_i(unit_free), .iss_valid_o(iss_valid),
    .iss_unit_o(iss_unit), .iss_seq_o(iss_seq), .iss_cls_o(iss_cls)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc();
  endtask

  task automatic disp(input int seq, input int cls, input int a, input bit ar,
                      input int b, input bit br);
    disp_valid = 1'b1;
    disp_seq   = 6'(seq);
    disp_cls   = 4'(cls);
    t0 = 5'(a); r0 = ar;
    t1 = 5'(b); r1 = br;
    cyc();
    disp_valid = 1'b0;
  endtask

  task automatic wake(input int port, input int tag);
    if (port == 0) begin wk0_v = 1'b1; wk0_tag = 5'(tag); end
    else           begin wk1_v = 1'b1; wk1_tag = 5'(tag); end
    cyc();
    wk0_v = 1'b0;
    wk1_v = 1'b0;
  endtask

  task automatic expect_iss(input int seq, input int unit, input string req);
    exp_q.push_back({3'(unit), 6'(seq)});
    exp_r.push_back(req);
  endtask

  task automatic quiet(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      check(iss_valid == 3'b000, req, "issue while blocked", int'(iss_valid), 0);
      cyc();
    end
  endtask

  // monitor: compares every issue against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mon_en && (iss_valid != 3'b000)) begin
      check($countones(iss_valid) == 1, "R6", "issue strobe one-hot",
            $countones(iss_valid), 1);
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected issue of seq", int'(iss_seq), -1);
      end else begin
        mon_e = exp_q.pop_front();
        mon_r = exp_r.pop_front();
        check(iss_seq == mon_e[5:0], mon_r, "issued seq", int'(iss_seq), int'(mon_e[5:0]));
        check(iss_unit == mon_e[8:6], "R6", "issue unit", int'(iss_unit), int'(mon_e[8:6]));
        check(iss_valid == (3'b001 << (mon_e[8:6] - 3'd2)), "R6", "strobe bit",
              int'(iss_valid), int'(3'b001 << (mon_e[8:6] - 3'd2)));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_order = 1'b1; unit_free = 3'b111;
    disp_valid = 1'b0; disp_seq = '0; disp_cls = '0;
    t0 = '0; t1 = '0; r0 = 1'b0; r1 = 1'b0;
    wk0_v = 1'b0; wk1_v = 1'b0; wk0_tag = '0; wk1_tag = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(disp_ready == 1'b1, "R1", "ready after reset", int'(disp_ready), 1);
    check(iss_valid == 3'b000, "R1", "no issue after reset", int'(iss_valid), 0);
    mon_en = 1'b1;
    cyc();

    // R3 latency for an entry ready at dispatch
    expect_iss(5, 2, "R3");
    disp(5, C_INT, 1, 1'b1, 2, 1'b1);
    @(negedge clk);
    check(iss_valid == 3'b000, "R3", "cycle after dispatch edge", int'(iss_valid), 0);
    cyc();
    @(negedge clk);
    check(iss_valid == 3'b001, "R3", "cycle after transfer edge", int'(iss_valid), 1);
    idle(2);

    // R2 wakeup in the dispatch cycle is captured
    expect_iss(12, 2, "R2");
    wk0_v = 1'b1; wk0_tag = 5'd8;
    disp(12, C_INT, 8, 1'b0, 3, 1'b1);
    wk0_v = 1'b0;
    @(negedge clk);
    check(iss_valid == 3'b000, "R2", "snooped entry one cycle early", int'(iss_valid), 0);
    cyc();
    @(negedge clk);
    check(iss_valid == 3'b001, "R2", "snooped entry issue", int'(iss_valid), 1);
    idle(2);

    // R2 unready entry waits; unmatched tag ignored; port 1 wakeup
    disp(10, C_INT, 7, 1'b0, 4, 1'b1);
    wake(0, 6);
    quiet(4, "R2");
    expect_iss(10, 2, "R2");
    wake(1, 7);
    @(negedge clk);
    check(iss_valid == 3'b000, "R3", "woken entry one cycle early", int'(iss_valid), 0);
    cyc();
    @(negedge clk);
    check(iss_valid == 3'b001, "R3", "woken entry issue", int'(iss_valid), 1);
    idle(2);

    // R4 arrival order differs from age order
    unit_free = 3'b000;
    disp(30, C_INT, 9, 1'b0, 0, 1'b1);
    disp(31, C_INT, 10, 1'b0, 0, 1'b1);
    disp(32, C_INT, 0, 1'b1, 0, 1'b1);
    wake(0, 10);
    wake(0, 9);
    idle(3);
    expect_iss(32, 2, "R4");
    expect_iss(31, 2, "R4");
    expect_iss(30, 2, "R4");
    unit_free = 3'b111;
    idle(5);

    // R5 oldest first across tag wrap
    in_order = 1'b0;
    unit_free = 3'b000;
    disp(62, C_INT, 0, 1'b1, 0, 1'b1);
    disp(1,  C_INT, 0, 1'b1, 0, 1'b1);
    disp(63, C_INT, 0, 1'b1, 0, 1'b1);
    disp(0,  C_INT, 0, 1'b1, 0, 1'b1);
    idle(3);
    expect_iss(62, 2, "R5");
    expect_iss(63, 2, "R5");
    expect_iss(0, 2, "R5");
    expect_iss(1, 2, "R5");
    unit_free = 3'b111;
    idle(6);
    in_order = 1'b1;

    // R6 steering by capability mask
    expect_iss(40, 3, "R6");
    expect_iss(41, 4, "R6");
    expect_iss(42, 2, "R6");
    disp(40, C_DIV, 0, 1'b1, 0, 1'b1);
    disp(41, C_MUL, 0, 1'b1, 0, 1'b1);
    disp(42, C_INT, 0, 1'b1, 0, 1'b1);
    idle(4);
    unit_free = 3'b110;
    expect_iss(43, 3, "R6");
    disp(43, C_INT, 0, 1'b1, 0, 1'b1);
    idle(3);
    unit_free = 3'b111;

    // R7 head blocked without a capable free unit
    unit_free = 3'b011;
    disp(50, C_MUL, 0, 1'b1, 0, 1'b1);
    disp(51, C_INT, 0, 1'b1, 0, 1'b1);
    quiet(3, "R7");
    expect_iss(50, 4, "R7");
    expect_iss(51, 2, "R7");
    unit_free = 3'b111;
    idle(4);

    // R8 full buffer; R9 oldest-ready transfer order
    unit_free = 3'b000;
    disp(13, C_INT, 20, 1'b0, 0, 1'b1);
    disp(11, C_INT, 20, 1'b0, 0, 1'b1);
    disp(14, C_INT, 20, 1'b0, 0, 1'b1);
    disp(12, C_INT, 20, 1'b0, 0, 1'b1);
    @(negedge clk);
    check(disp_ready == 1'b0, "R8", "ready when full", int'(disp_ready), 0);
    disp_valid = 1'b1; disp_seq = 6'd33; disp_cls = 4'(C_INT);
    r0 = 1'b1; r1 = 1'b1;
    idle(2);
    disp_valid = 1'b0;
    @(negedge clk);
    check(disp_ready == 1'b0, "R8", "still full after dropped dispatch", int'(disp_ready), 0);
    wake(0, 20);
    cyc();
    @(negedge clk);
    check(disp_ready == 1'b1, "R8", "ready after first transfer", int'(disp_ready), 1);
    idle(4);
    expect_iss(11, 2, "R9");
    expect_iss(12, 2, "R9");
    expect_iss(13, 2, "R9");
    expect_iss(14, 2, "R9");
    unit_free = 3'b111;
    idle(8);

    // R10 everything issued exactly once
    check(exp_q.size() == 0, "R10", "pending expected issues", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule